// File: doc/BRIEF.md
# Private Interrupt Priority Selector

This block picks, for one processor, the best interrupt to signal from among its 32 private interrupts (16 raised by software, 16 from local peripherals). Each cycle it forms an eligibility vector from the pending latches, the trigger mode, the line levels, the enable and active bits, and the group settings. The group settings are a group bit per interrupt, a modifier bit per interrupt, three global group enables and a control that turns off the security split.

A one-cycle start strobe launches a registered scan. The scan visits interrupt IDs 0 to 31 in ascending order, one per clock. It keeps the candidate with the numerically smallest priority, so the lowest ID wins a tie. At the end it publishes the winner's ID, priority and group code, and pulses a done flag. The published result stays unchanged until the next scan ends. A result priority of 0xFF means that no interrupt is pending.

The sequencer has three states. `ST_IDLE` waits for a start. `ST_SCAN` examines one ID per cycle. `ST_DONE` lasts one cycle and drives done. The transitions are:
- idle→scan on start
- scan→scan while the index is below 31
- scan→done when ID 31 is examined
- done→scan on start in the done cycle
- done→idle otherwise

Top module: `prv_irq_picker`

## Requirements
- R1: An interrupt is pending when its latch bit is set, or when its trigger bit is 0 (level) and its line is 1. A line that is high on a trigger-bit-1 (edge) interrupt does not make it pending.
- R2: A pending interrupt appears in `elig_vec` only if its enable bit is 1 and its active bit is 0.
- R3: While `sec_off` is 1, every modifier bit is treated as 0.
- R4: An interrupt passes the group mask in three cases: its group bit is 1 and `ena_g1ns` is 1; group 0 with modifier 1 and `ena_g1s` is 1; group 0 with modifier 0 and `ena_g0` is 1. `elig_vec` is the AND of R1, R2 and this mask.
- R5: The winner is the eligible interrupt with the numerically lowest priority value.
- R6: Among eligible interrupts of equal priority, the lowest ID wins.
- R7: When nothing is eligible, or every eligible interrupt has priority 0xFF, the result is priority 0xFF, ID 0 and group code 0.
- R8: `scan_done` is high for exactly one cycle. It rises on the 32nd rising edge after the edge that samples `upd_go`.
- R9: The result outputs hold their value until the next `scan_done`. A start strobe during a scan has no effect: it causes no extra done pulse and does not change the timing.
- R10: A start strobe sampled while `scan_done` is high begins a new scan at once. That scan's done arrives 32 edges later.
- R11: `win_grp` is 2 when the winner's group bit is 1. Otherwise it is 1 when the winner's effective modifier is 1, and 0 when it is 0.
- R12: Synchronous reset sets priority 0xFF, ID 0, group 0 and done 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_go | input | 1 | Start strobe for one scan |
| pend_latch | input | 32 | Pending latch bits |
| edge_cfg | input | 32 | Trigger mode, 1 = edge, 0 = level |
| line_lvl | input | 32 | Current interrupt line levels |
| irq_en | input | 32 | Enable bits |
| irq_act | input | 32 | Active bits |
| grp_sel | input | 32 | Group bit, 1 = group 1 non-secure |
| grp_mod | input | 32 | Group modifier bits |
| ena_g0 | input | 1 | Global group 0 enable |
| ena_g1s | input | 1 | Global group 1 secure enable |
| ena_g1ns | input | 1 | Global group 1 non-secure enable |
| sec_off | input | 1 | Security split off: modifiers forced to 0 |
| prio_flat | input | 256 | Eight-bit priorities, ID n at bits [8n+7:8n] |
| elig_vec | output | 32 | Eligibility vector |
| win_id | output | 5 | Winning interrupt ID |
| win_prio | output | 8 | Winning priority, 0xFF = none |
| win_grp | output | 2 | Winner group code |
| scan_done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can fall in the same cycle: the final commit with its done pulse, and the acceptance of a new start. The bench provokes this by raising the strobe with fresh inputs in the very cycle that shows done. It judges the outcome by requiring both results to come out of the scoreboard in order, with the second done exactly 32 edges later. A strobe raised in the middle of a scan is also checked: it must leave both the timing and the held result untouched.

// File: rtl/pip_pkg.sv
package pip_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } scan_st_t;

    localparam logic [1:0] GRP_G0   = 2'd0;
    localparam logic [1:0] GRP_G1S  = 2'd1;
    localparam logic [1:0] GRP_G1NS = 2'd2;

    function automatic logic [1:0] grp_code(input logic g, input logic m);
        if (g)      return GRP_G1NS;
        else if (m) return GRP_G1S;
        else        return GRP_G0;
    endfunction

endpackage

// File: rtl/pip_elig.sv
module pip_elig #(
    parameter int N = 32
) (
    input  logic [N-1:0] pend_latch,
    input  logic [N-1:0] edge_cfg,
    input  logic [N-1:0] line_lvl,
    input  logic [N-1:0] irq_en,
    input  logic [N-1:0] irq_act,
    input  logic [N-1:0] grp_sel,
    input  logic [N-1:0] grp_mod,
    input  logic         ena_g0,
    input  logic         ena_g1s,
    input  logic         ena_g1ns,
    input  logic         sec_off,
    output logic [N-1:0] elig,
    output logic [N-1:0] mod_eff
);

    logic [N-1:0] pend_raw;
    logic [N-1:0] pend_live;
    logic [N-1:0] grp_ok;

    always_comb begin
        mod_eff   = sec_off ? '0 : grp_mod;
        pend_raw  = pend_latch | (~edge_cfg & line_lvl);
        pend_live = pend_raw & irq_en & ~irq_act;
        grp_ok    = ({N{ena_g1ns}} & grp_sel)
                  | ({N{ena_g1s}}  & ~grp_sel & mod_eff)
                  | ({N{ena_g0}}   & ~grp_sel & ~mod_eff);
        elig      = pend_live & grp_ok;
    end

endmodule

// File: rtl/pip_scan.sv
module pip_scan
    import pip_pkg::*;
#(
    parameter int N  = 32,
    parameter int PW = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [N-1:0]    elig,
    input  logic [N*PW-1:0] prio_flat,
    input  logic [N-1:0]    grp_sel,
    input  logic [N-1:0]    mod_eff,
    output logic [IW-1:0]   res_id,
    output logic [PW-1:0]   res_prio,
    output logic [1:0]      res_grp,
    output logic            done
);

    localparam logic [IW-1:0] LAST_ID   = IW'(N - 1);
    localparam logic [PW-1:0] PRIO_NONE = {PW{1'b1}};

    scan_st_t        state, state_nx;
    logic [IW-1:0]   idx;
    logic [PW-1:0]   cand_prio;
    logic [IW-1:0]   cand_id;
    logic [1:0]      cand_grp;
    logic [PW-1:0]   cur_prio;
    logic            hit;
    logic            at_last;

    assign cur_prio = prio_flat[idx*PW +: PW];
    assign hit      = elig[idx] && (cur_prio < cand_prio);
    assign at_last  = (idx == LAST_ID);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)   state_nx = ST_SCAN;
            ST_SCAN: if (at_last) state_nx = ST_DONE;
            ST_DONE: state_nx = start ? ST_SCAN : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            idx       <= '0;
            cand_prio <= PRIO_NONE;
            cand_id   <= '0;
            cand_grp  <= GRP_G0;
            res_prio  <= PRIO_NONE;
            res_id    <= '0;
            res_grp   <= GRP_G0;
        end else begin
            unique case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        idx       <= '0;
                        cand_prio <= PRIO_NONE;
                        cand_id   <= '0;
                        cand_grp  <= GRP_G0;
                    end
                end
                ST_SCAN: begin
                    if (hit) begin
                        cand_prio <= cur_prio;
                        cand_id   <= idx;
                        cand_grp  <= grp_code(grp_sel[idx], mod_eff[idx]);
                    end
                    if (at_last) begin
                        res_prio <= hit ? cur_prio : cand_prio;
                        res_id   <= hit ? idx : cand_id;
                        res_grp  <= hit ? grp_code(grp_sel[idx], mod_eff[idx]) : cand_grp;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        done = (state == ST_DONE);
    end

endmodule

// File: rtl/prv_irq_picker.sv
module prv_irq_picker #(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 8,
    localparam int ID_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    upd_go,
    input  logic [NUM_IRQ-1:0]      pend_latch,
    input  logic [NUM_IRQ-1:0]      edge_cfg,
    input  logic [NUM_IRQ-1:0]      line_lvl,
    input  logic [NUM_IRQ-1:0]      irq_en,
    input  logic [NUM_IRQ-1:0]      irq_act,
    input  logic [NUM_IRQ-1:0]      grp_sel,
    input  logic [NUM_IRQ-1:0]      grp_mod,
    input  logic                    ena_g0,
    input  logic                    ena_g1s,
    input  logic                    ena_g1ns,
    input  logic                    sec_off,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    output logic [NUM_IRQ-1:0]      elig_vec,
    output logic [ID_W-1:0]         win_id,
    output logic [PRIO_W-1:0]       win_prio,
    output logic [1:0]              win_grp,
    output logic                    scan_done
);

    logic [NUM_IRQ-1:0] mod_eff;

    pip_elig #(.N(NUM_IRQ)) u_elig (
        .pend_latch (pend_latch),
        .edge_cfg   (edge_cfg),
        .line_lvl   (line_lvl),
        .irq_en     (irq_en),
        .irq_act    (irq_act),
        .grp_sel    (grp_sel),
        .grp_mod    (grp_mod),
        .ena_g0     (ena_g0),
        .ena_g1s    (ena_g1s),
        .ena_g1ns   (ena_g1ns),
        .sec_off    (sec_off),
        .elig       (elig_vec),
        .mod_eff    (mod_eff)
    );

    pip_scan #(.N(NUM_IRQ), .PW(PRIO_W)) u_scan (
        .clk       (clk),
        .rst       (rst),
        .start     (upd_go),
        .elig      (elig_vec),
        .prio_flat (prio_flat),
        .grp_sel   (grp_sel),
        .mod_eff   (mod_eff),
        .res_id    (win_id),
        .res_prio  (win_prio),
        .res_grp   (win_grp),
        .done      (scan_done)
    );

endmodule

// File: rtl/pip_chk.sv
module pip_chk #(
    parameter int N  = 32,
    parameter int PW = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input logic          clk,
    input logic          rst,
    input logic [N-1:0]  irq_en,
    input logic [N-1:0]  irq_act,
    input logic          ena_g0,
    input logic          ena_g1ns,
    input logic          sec_off,
    input logic [N-1:0]  elig_vec,
    input logic [IW-1:0] win_id,
    input logic [PW-1:0] win_prio,
    input logic [1:0]    win_grp,
    input logic          scan_done
);

    logic armed;
    always_ff @(posedge clk) armed <= !rst;

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        scan_done |=> !scan_done);

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (armed && !scan_done) |-> ($stable(win_prio) && $stable(win_id) && $stable(win_grp)));

    assert_none_result_R7: assert property (@(posedge clk) disable iff (rst)
        (scan_done && win_prio == {PW{1'b1}}) |-> (win_id == '0 && win_grp == 2'd0));

    assert_en_act_gate_R2: assert property (@(posedge clk) disable iff (rst)
        (elig_vec & ~(irq_en & ~irq_act)) == '0);

    assert_secoff_g1s_R3: assert property (@(posedge clk) disable iff (rst)
        (sec_off && !ena_g0 && !ena_g1ns) |-> (elig_vec == '0));

endmodule

bind prv_irq_picker pip_chk #(.N(NUM_IRQ), .PW(PRIO_W)) u_pip_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_en    (irq_en),
    .irq_act   (irq_act),
    .ena_g0    (ena_g0),
    .ena_g1ns  (ena_g1ns),
    .sec_off   (sec_off),
    .elig_vec  (elig_vec),
    .win_id    (win_id),
    .win_prio  (win_prio),
    .win_grp   (win_grp),
    .scan_done (scan_done)
);

// File: tb/test_prv_irq_picker.sv
module test_prv_irq_picker;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic upd_go = 1'b0;
    logic [31:0] pend_l = '0, edge_c = '0, line = '0, en = '0, act = '0, grp = '0, gmod = '0;
    logic g0 = 1'b0, g1s = 1'b0, g1ns = 1'b0, secoff = 1'b0;
    logic [7:0] pr [32];
    logic [255:0] prio_flat;
    logic [31:0] elig_vec;
    logic [4:0]  win_id;
    logic [7:0]  win_prio;
    logic [1:0]  win_grp;
    logic        scan_done;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [4:0] id;
        logic [7:0] prio;
        logic [1:0] grp;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;   // 125 MHz

    always_comb begin
        for (int i = 0; i < 32; i++) prio_flat[i*8 +: 8] = pr[i];
    end

    prv_irq_picker i_prv_irq_picker (
        .clk(clk), .rst(rst), .upd_go(upd_go),
        .pend_latch(pend_l), .edge_cfg(edge_c), .line_lvl(line),
        .irq_en(en), .irq_act(act), .grp_sel(grp), .grp_mod(gmod),
        .ena_g0(g0), .ena_g1s(g1s), .ena_g1ns(g1ns), .sec_off(secoff),
        .prio_flat(prio_flat), .elig_vec(elig_vec), .win_id(win_id),
        .win_prio(win_prio), .win_grp(win_grp), .scan_done(scan_done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act_v, exp_v);
        end
    endtask

    function automatic logic [31:0] m_elig();
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            logic p, ok, m, gok;
            p   = pend_l[i] || (!edge_c[i] && line[i]);
            ok  = p && en[i] && !act[i];
            m   = secoff ? 1'b0 : gmod[i];
            gok = (grp[i] && g1ns) || (!grp[i] && m && g1s) || (!grp[i] && !m && g0);
            r[i] = ok && gok;
        end
        return r;
    endfunction

    function automatic exp_t m_pick(input string tag);
        exp_t e;
        logic [31:0] el;
        el = m_elig();
        e.id = 0; e.prio = 8'hFF; e.grp = 0; e.tag = tag;
        for (int i = 0; i < 32; i++) begin
            if (el[i] && pr[i] < e.prio) begin
                e.prio = pr[i];
                e.id   = 5'(i);
                e.grp  = grp[i] ? 2'd2 : ((!secoff && gmod[i]) ? 2'd1 : 2'd0);
            end
        end
        return e;
    endfunction

    // monitor: pop and compare at each done
    always @(negedge clk) begin
        if (!rst && scan_done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R9 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(win_id == e.id, {e.tag, " id"}, 32'(win_id), 32'(e.id));
                chk(win_prio == e.prio, {e.tag, " prio"}, 32'(win_prio), 32'(e.prio));
                chk(win_grp == e.grp, {e.tag, " grp R11"}, 32'(win_grp), 32'(e.grp));
            end
        end
    end

    // called at a negedge: push expectation, raise go, drop it at next negedge
    task automatic launch(input string tag);
        sb.push_back(m_pick(tag));
        upd_go = 1'b1;
        @(negedge clk);
        upd_go = 1'b0;
    endtask

    // called at the negedge after launch; counts negedges to done (R8)
    task automatic wait_done(input string tag);
        int cnt = 1;
        while (!scan_done && cnt < 60) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == 33, {tag, " R8 latency"}, 32'(cnt), 32'd33);
    endtask

    task automatic run(input string tag);
        @(negedge clk);
        launch(tag);
        wait_done(tag);
        @(negedge clk);
        chk(!scan_done, {tag, " R8 single pulse"}, 32'(scan_done), 32'd0);
    endtask

    task automatic base();
        pend_l = '1; edge_c = '1; line = '0; en = '1; act = '0;
        grp = '1; gmod = '0; g0 = 0; g1s = 0; g1ns = 1; secoff = 0;
        for (int i = 0; i < 32; i++) pr[i] = 8'h60;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) pr[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(win_prio == 8'hFF, "R12 prio", 32'(win_prio), 32'hFF);
        chk(win_id == 0, "R12 id", 32'(win_id), 0);
        chk(win_grp == 0, "R12 grp", 32'(win_grp), 0);
        chk(!scan_done, "R12 done", 32'(scan_done), 0);

        // R1: latch or level-high line
        base();
        pend_l = 32'h0000_0010; edge_c = 32'hFFFF_0000; line = 32'h00F0_0F00;
        for (int i = 0; i < 32; i++) pr[i] = 8'h80 + 8'(i);
        pr[9] = 8'h20; pr[21] = 8'h10;
        #1 chk(elig_vec == 32'h0000_0F10, "R1 elig", elig_vec, 32'h0000_0F10);
        run("R1 scan");

        // R2: enable and active gating
        base();
        en = 32'h0000_FF00; act = 32'h0000_0F00;
        pr[3] = 8'h01; pr[13] = 8'h30;
        #1 chk(elig_vec == 32'h0000_F000, "R2 elig", elig_vec, 32'h0000_F000);
        run("R2 scan");

        // R4/R11: group mask terms
        base();
        grp = 32'h0000_00FF; gmod = 32'h0000_FF00;
        pr[5] = 8'h05; pr[12] = 8'h20; pr[20] = 8'h10;
        g0 = 1; g1s = 1; g1ns = 1;
        run("R4 all groups");
        g0 = 0; g1s = 1; g1ns = 0;
        #1 chk(elig_vec == 32'h0000_FF00, "R4 g1s only", elig_vec, 32'h0000_FF00);
        run("R4 R11 g1s");
        g0 = 1; g1s = 0; g1ns = 0;
        #1 chk(elig_vec == 32'hFFFF_0000, "R4 g0 only", elig_vec, 32'hFFFF_0000);
        run("R4 R11 g0");

        // R3: security off clears modifiers
        secoff = 1; g0 = 0; g1s = 1;
        #1 chk(elig_vec == 32'h0, "R3 g1s masked", elig_vec, 32'h0);
        run("R3 none");
        g0 = 1; g1s = 0;
        #1 chk(elig_vec == 32'hFFFF_FF00, "R3 mod as g0", elig_vec, 32'hFFFF_FF00);
        pr[20] = 8'h40;
        run("R3 R11 g0 via secoff");

        // R5 / R6
        base();
        for (int i = 0; i < 32; i++) pr[i] = 8'h90;
        pr[31] = 8'h00;
        run("R5 last id");
        base();
        pr[7] = 8'h30; pr[3] = 8'h30; pr[25] = 8'h30;
        run("R6 tie");

        // R7: all at 0xFF, and nothing eligible
        base();
        for (int i = 0; i < 32; i++) pr[i] = 8'hFF;
        run("R7 all FF");
        base(); en = '0;
        run("R7 empty");

        // R9: strobe during scan ignored, result held
        base(); pr[17] = 8'h11;
        @(negedge clk);
        launch("R9 scan");
        begin
            int cnt = 1;
            while (!scan_done && cnt < 60) begin
                if (cnt == 5) chk(win_prio == 8'hFF && win_id == 0, "R9 hold", 32'(win_prio), 32'hFF);
                upd_go = (cnt == 10);
                @(negedge clk);
                cnt++;
            end
            upd_go = 1'b0;
            chk(cnt == 33, "R9 latency", 32'(cnt), 33);
        end
        repeat (45) @(negedge clk);
        chk(win_id == 17 && win_prio == 8'h11, "R9 held after", 32'(win_id), 17);

        // R10: start in done cycle
        base(); pr[2] = 8'h22;
        @(negedge clk);
        launch("R10 first");
        begin
            int cnt = 1;
            while (!scan_done && cnt < 60) begin
                @(negedge clk);
                cnt++;
            end
            chk(cnt == 33, "R10 first latency", 32'(cnt), 33);
        end
        pr[2] = 8'h60; pr[28] = 8'h07;
        launch("R10 second");
        wait_done("R10 second");
        repeat (5) @(negedge clk);
        chk(sb.size() == 0, "R10 queue drained", 32'(sb.size()), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule